// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit lets a 16-bit data path read and write a store of 24-bit program words. Each access names an 8-bit page, held in a page register, and a 16-bit effective address. Together these form a 24-bit access address. Because consecutive program words sit two addresses apart, effective-address bit 0 does not choose a word. It selects a byte lane instead.

The 24-bit words appear as two 16-bit views that share one address range. The low view holds word bits 15:0. The high view holds bits 23:16 in its lower byte. Its upper byte is a phantom that always reads as zero and ignores writes.

The page register's most significant bit chooses between two regions:
- A small writable user region.
- A read-only configuration region whose contents are computed from two parameters.

Requests use a valid/ready handshake. A read returns its data one cycle after it is accepted. A write aimed at the configuration region is dropped and flagged with a one-cycle error pulse.

Top module: `pmem_table_port`

## Requirements
- R1: While `rst` is high at a clock edge, the page register clears to 0, `rvalid`, `write_error` and `req_ready` go low, and `req_ready` returns high at the first edge after `rst` falls. User memory contents survive a reset.
- R2: The region is chosen by page bit PAGE_W-1: 0 selects user space and 1 selects configuration space. The other page bits do not affect the access. The word index is `req_ea[UAW:1]` (user) or `req_ea[CAW:1]` (configuration), so word addresses wrap modulo the region depth. `req_ea[0]` is the byte select.
- R3: Read-low in word size (`req_op`=2'b00, `req_byte`=0) returns word bits 15:0.
- R4: Read-low in byte size (`req_op`=2'b00, `req_byte`=1) returns bits 15:8 when byte select is 1 and bits 7:0 when it is 0. The result is placed in `rdata[7:0]`, with `rdata[15:8]` zero.
- R5: Read-high in word size (`req_op`=2'b01, `req_byte`=0) returns word bits 23:16 in `rdata[7:0]`, with the phantom byte `rdata[15:8]` always zero.
- R6: Read-high in byte size returns bits 23:16 in `rdata[7:0]` when byte select is 0. It returns 16'h0000 when byte select is 1, because that selects the phantom byte.
- R7: Write-low (`req_op`=2'b10) to user space writes `req_wdata` into bits 15:0 in word size. In byte size it writes `req_wdata[7:0]` into bits 15:8 (byte select 1) or bits 7:0 (byte select 0), and leaves the other bits unchanged.
- R8: Write-high (`req_op`=2'b11) to user space writes `req_wdata[7:0]` into bits 23:16, and `req_wdata[15:8]` is discarded. A byte-size write-high with byte select 1 targets the phantom byte and changes nothing.
- R9: A write accepted while configuration space is selected changes no stored word and drives `write_error` high for exactly the following cycle. `write_error` is otherwise low.
- R10: Configuration word i reads as (CFG_BASE + CFG_STEP*i) mod 2^24.
- R11: `rvalid` is high in the cycle after an accepted read, and low after an accepted write or an idle cycle. A page load takes effect at the next clock edge, so an access in the same cycle uses the old page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_we | input | 1 | Load the page register |
| page_wdata | input | PAGE_W | New page value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts requests |
| req_op | input | 2 | 00 read-low, 01 read-high, 10 write-low, 11 write-high |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| req_ea | input | EA_W | Effective address; bit 0 is the byte select |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read result |
| rvalid | output | 1 | `rdata` valid this cycle |
| write_error | output | 1 | One-cycle pulse after a rejected configuration write |

## Verification
The bench builds the unit with USER_DEPTH=32 and CFG_DEPTH=8, keeping PAGE_W=8 and EA_W=16. With these depths, addresses above 64 and 16 wrap back onto existing words, so index aliasing in both regions is reached with short address sweeps. The small user store also lets every word be filled before any read, so the reference model knows every read result. The bench uses non-zero CFG_BASE and CFG_STEP values, which make every configuration byte distinct enough to expose a lane or phantom mix-up.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   typedef enum logic [1:0] {
      OP_RD_LO = 2'b00,
      OP_RD_HI = 2'b01,
      OP_WR_LO = 2'b10,
      OP_WR_HI = 2'b11
   } tbl_op_e;

   localparam int PWORD_W = 24;
   localparam int DWORD_W = 16;
   localparam int LANES   = PWORD_W / 8;

   function automatic logic [PWORD_W-1:0] cfg_word(input logic [PWORD_W-1:0] base,
                                                    input logic [PWORD_W-1:0] step,
                                                    input int unsigned        idx);
      logic [PWORD_W-1:0] k;
      logic [PWORD_W-1:0] prod;
      k    = PWORD_W'(idx);
      prod = step * k;
      return base + prod;
   endfunction

endpackage

// File: rtl/pmt_addr_decode.sv
module pmt_addr_decode #(
   parameter int PAGE_W = 8,
   parameter int EA_W   = 16,
   parameter int UAW    = 6,
   parameter int CAW    = 4
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [EA_W-1:0]   ea,
   output logic              cfg_sel,
   output logic              bsel,
   output logic [UAW-1:0]    uidx,
   output logic [CAW-1:0]    cidx
);
   logic page_unused;
   logic ea_unused;

   assign cfg_sel     = page[PAGE_W-1];
   assign bsel        = ea[0];
   assign uidx        = ea[UAW:1];
   assign cidx        = ea[CAW:1];
   assign page_unused = ^page;
   assign ea_unused   = ^ea;
endmodule

// File: rtl/pmt_lane_map.sv
module pmt_lane_map
   import pmt_pkg::*;
(
   input  tbl_op_e              op,
   input  logic                 byte_mode,
   input  logic                 bsel,
   input  logic [DWORD_W-1:0]   wdata,
   input  logic [PWORD_W-1:0]   word,
   output logic [DWORD_W-1:0]   rd_fmt,
   output logic [LANES-1:0]     be,
   output logic [PWORD_W-1:0]   wword
);
   always_comb begin
      rd_fmt = '0;
      be     = '0;
      wword  = byte_mode ? {3{wdata[7:0]}} : {wdata[7:0], wdata};
      unique case (op)
         OP_RD_LO: begin
            if (!byte_mode)  rd_fmt = word[15:0];
            else if (bsel)   rd_fmt = {8'h00, word[15:8]};
            else             rd_fmt = {8'h00, word[7:0]};
         end
         OP_RD_HI: begin
            if (!(byte_mode && bsel)) rd_fmt = {8'h00, word[23:16]};
         end
         OP_WR_LO: begin
            if (!byte_mode)  be = 3'b011;
            else if (bsel)   be = 3'b010;
            else             be = 3'b001;
         end
         OP_WR_HI: begin
            if (!(byte_mode && bsel)) be = 3'b100;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pmt_word_store.sv
module pmt_word_store
   import pmt_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic [LANES-1:0]   we_lane,
   input  logic [AW-1:0]      waddr,
   input  logic [PWORD_W-1:0] wword,
   input  logic [AW-1:0]      raddr,
   output logic [PWORD_W-1:0] rword
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we_lane[g]) lane_mem[waddr] <= wword[g*8 +: 8];
      end
      assign rword[g*8 +: 8] = lane_mem[raddr];
   end
endmodule

// File: rtl/pmt_cfg_rom.sv
module pmt_cfg_rom
   import pmt_pkg::*;
#(
   parameter int                 CAW      = 4,
   parameter logic [PWORD_W-1:0] CFG_BASE = 24'h3C0011,
   parameter logic [PWORD_W-1:0] CFG_STEP = 24'h010101
) (
   input  logic [CAW-1:0]     raddr,
   output logic [PWORD_W-1:0] rword
);
   assign rword = cfg_word(CFG_BASE, CFG_STEP, {{(32-CAW){1'b0}}, raddr});
endmodule

// File: rtl/pmem_table_port.sv
module pmem_table_port
   import pmt_pkg::*;
#(
   parameter int                 PAGE_W     = 8,
   parameter int                 EA_W       = 16,
   parameter int                 USER_DEPTH = 64,
   parameter int                 CFG_DEPTH  = 16,
   parameter logic [PWORD_W-1:0] CFG_BASE   = 24'h3C0011,
   parameter logic [PWORD_W-1:0] CFG_STEP   = 24'h010101
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              page_we,
   input  logic [PAGE_W-1:0] page_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic              req_byte,
   input  logic [EA_W-1:0]   req_ea,
   input  logic [15:0]       req_wdata,
   output logic [15:0]       rdata,
   output logic              rvalid,
   output logic              write_error
);
   localparam int UAW = $clog2(USER_DEPTH);
   localparam int CAW = $clog2(CFG_DEPTH);

   if (PAGE_W < 2)                   begin : g_bad_page  $error("PAGE_W must be at least 2"); end
   if (USER_DEPTH != (1 << UAW))     begin : g_bad_udep  $error("USER_DEPTH must be a power of two"); end
   if (CFG_DEPTH != (1 << CAW))      begin : g_bad_cdep  $error("CFG_DEPTH must be a power of two"); end
   if (UAW < 1 || UAW > EA_W - 1)    begin : g_bad_uaw   $error("USER_DEPTH out of range for EA_W"); end
   if (CAW < 1 || CAW > EA_W - 1)    begin : g_bad_caw   $error("CFG_DEPTH out of range for EA_W"); end

   // page register and ready
   logic [PAGE_W-1:0] page_q;
   logic              ready_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         page_q  <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         if (page_we) page_q <= page_wdata;
      end
   end
   assign req_ready = ready_q;

   AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
      ($past(page_we) && !$past(rst)) |-> (page_q == $past(page_wdata))); // R11

   // address formation
   logic           cfg_sel, bsel;
   logic [UAW-1:0] uidx;
   logic [CAW-1:0] cidx;

   pmt_addr_decode #(.PAGE_W(PAGE_W), .EA_W(EA_W), .UAW(UAW), .CAW(CAW)) u_dec (
      .page(page_q), .ea(req_ea), .cfg_sel(cfg_sel), .bsel(bsel), .uidx(uidx), .cidx(cidx));

   tbl_op_e op;
   logic    acc, is_wr;
   assign op    = tbl_op_e'(req_op);
   assign acc   = req_valid && ready_q;
   assign is_wr = req_op[1];

   // storage
   logic [PWORD_W-1:0] u_word, c_word, sel_word, wword;
   logic [LANES-1:0]   be, st_we;
   logic [15:0]        rd_fmt;

   pmt_cfg_rom #(.CAW(CAW), .CFG_BASE(CFG_BASE), .CFG_STEP(CFG_STEP)) u_rom (
      .raddr(cidx), .rword(c_word));

   assign sel_word = cfg_sel ? c_word : u_word;

   pmt_lane_map u_lane (
      .op(op), .byte_mode(req_byte), .bsel(bsel), .wdata(req_wdata), .word(sel_word),
      .rd_fmt(rd_fmt), .be(be), .wword(wword));

   assign st_we = be & {LANES{acc && is_wr && !cfg_sel}};

   AST_NO_CFG_STORE: assert property (@(posedge clk) disable iff (rst)
      (|st_we) |-> !cfg_sel); // R9

   pmt_word_store #(.DEPTH(USER_DEPTH)) u_store (
      .clk(clk), .we_lane(st_we), .waddr(uidx), .wword(wword), .raddr(uidx), .rword(u_word));

   // response
   always_ff @(posedge clk) begin
      if (rst) begin
         rvalid      <= 1'b0;
         write_error <= 1'b0;
         rdata       <= '0;
      end else begin
         rvalid      <= acc && !is_wr;
         write_error <= acc && is_wr && cfg_sel;
         if (acc && !is_wr) rdata <= rd_fmt;
      end
   end

   AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> $past(acc && !is_wr)); // R11
   AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
      (acc && !is_wr) |=> rvalid); // R11
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      write_error |-> $past(acc && is_wr && cfg_sel)); // R9
   AST_PHANTOM_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rvalid && $past(req_op == OP_RD_HI)) |-> (rdata[15:8] == 8'h00)); // R5
endmodule

// File: tb/tb_pmem_table_port.sv
module tb_pmem_table_port;
   localparam int CLK_PERIOD = 10;
   localparam int UDEP = 32;
   localparam int CDEP = 8;
   localparam bit [23:0] CBASE = 24'h5A1203;
   localparam bit [23:0] CSTEP = 24'h0B1D27;

   logic clk = 0, rst = 1;
   logic page_we = 0; logic [7:0] page_wdata = 0;
   logic req_valid = 0, req_byte = 0; logic [1:0] req_op = 0;
   logic [15:0] req_ea = 0, req_wdata = 0;
   logic req_ready, rvalid, write_error; logic [15:0] rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmem_table_port #(.PAGE_W(8), .EA_W(16), .USER_DEPTH(UDEP), .CFG_DEPTH(CDEP),
                     .CFG_BASE(CBASE), .CFG_STEP(CSTEP)) dut (
      .clk(clk), .rst(rst), .page_we(page_we), .page_wdata(page_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_byte(req_byte),
      .req_ea(req_ea), .req_wdata(req_wdata), .rdata(rdata), .rvalid(rvalid),
      .write_error(write_error));

   int total = 0, bad = 0;
   bit done = 0;
   bit [23:0] umem [UDEP];
   bit [7:0]  m_page = 0;

   function automatic bit [23:0] cfg_ref(int i);
      return 24'((CBASE + CSTEP * 24'(i)) & 24'hFFFFFF);
   endfunction

   function automatic bit [15:0] rd_ref(bit [23:0] w, bit hi, bit bm, bit bs);
      if (hi) return (bm && bs) ? 16'h0000 : {8'h00, w[23:16]};
      if (!bm) return w[15:0];
      return bs ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, check outputs at the next negedge
   task automatic cyc(bit v, bit [1:0] op, bit bm, bit [15:0] ea, bit [15:0] wd,
                      bit pwe, bit [7:0] pwd, string tag);
      bit cfg; bit [23:0] w; int ui; bit exp_rv, exp_err; bit [15:0] exp_rd;
      req_valid = v; req_op = op; req_byte = bm; req_ea = ea; req_wdata = wd;
      page_we = pwe; page_wdata = pwd;
      cfg = m_page[7];
      ui = (ea >> 1) % UDEP;
      w = cfg ? cfg_ref((ea >> 1) % CDEP) : umem[ui];
      exp_rv  = v && !op[1];
      exp_err = v && op[1] && cfg;
      exp_rd  = rd_ref(w, op[0], bm, ea[0]);
      if (v && op[1] && !cfg) begin
         if (!op[0]) begin
            if (!bm) w[15:0] = wd;
            else if (ea[0]) w[15:8] = wd[7:0];
            else w[7:0] = wd[7:0];
         end else if (!(bm && ea[0])) w[23:16] = wd[7:0];
         umem[ui] = w;
      end
      if (pwe) m_page = pwd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; page_we = 0;
      chk({tag, " R11 rvalid"}, rvalid, exp_rv);
      chk({tag, " R9 write_error"}, write_error, exp_err);
      if (exp_rv) chk({tag, " rdata"}, rdata, exp_rd);
   endtask

   task automatic do_reset();
      rst = 1;
      repeat (2) @(negedge clk);
      chk("R1 ready in reset", req_ready, 0);
      chk("R1 rvalid in reset", rvalid, 0);
      chk("R1 write_error in reset", write_error, 0);
      m_page = 0;
      rst = 0;
      @(negedge clk);
      chk("R1 ready after reset", req_ready, 1);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R7 R8: fill user space; upper write byte must be discarded
      for (int i = 0; i < UDEP; i++) begin
         cyc(1, 2'b10, 0, 16'(2*i), 16'(16'hA000 + i*16'h0137), 0, 0, "R7 fill");
         cyc(1, 2'b11, 0, 16'(2*i), 16'(16'hEE00 + i*7), 0, 0, "R8 fill");
      end
      // R3 R5: word reads of every word
      for (int i = 0; i < UDEP; i++) begin
         cyc(1, 2'b00, 0, 16'(2*i), 0, 0, 0, "R3 word read-low");
         cyc(1, 2'b01, 0, 16'(2*i), 0, 0, 0, "R5 word read-high");
      end
      // R4 R6: byte reads on both lanes
      for (int i = 0; i < 8; i++) begin
         for (int b = 0; b < 2; b++) begin
            cyc(1, 2'b00, 1, 16'(2*i + b), 0, 0, 0, "R4 byte read-low");
            cyc(1, 2'b01, 1, 16'(2*i + b), 0, 0, 0, "R6 byte read-high");
         end
      end
      // R7 byte writes, R8 phantom write ignored
      cyc(1, 2'b10, 1, 16'd7, 16'hFF3C, 0, 0, "R7 byte write hi lane");
      cyc(1, 2'b10, 1, 16'd6, 16'hFFC3, 0, 0, "R7 byte write lo lane");
      cyc(1, 2'b00, 0, 16'd6, 0, 0, 0, "R7 readback");
      cyc(1, 2'b01, 0, 16'd6, 0, 0, 0, "R7 upper untouched");
      cyc(1, 2'b11, 1, 16'd9, 16'h0077, 0, 0, "R8 phantom write");
      cyc(1, 2'b01, 0, 16'd8, 0, 0, 0, "R8 phantom no effect");
      cyc(1, 2'b11, 1, 16'd8, 16'h9955, 0, 0, "R8 byte write-high");
      cyc(1, 2'b01, 1, 16'd8, 0, 0, 0, "R8 readback");
      // R2 aliasing and non-MSB page bits
      cyc(1, 2'b00, 0, 16'(2*UDEP + 6), 0, 0, 0, "R2 user alias");
      cyc(0, 0, 0, 0, 0, 1, 8'h35, "R2 page load");
      cyc(1, 2'b00, 0, 16'd6, 0, 0, 0, "R2 page low bits ignored");
      // R11: page load in the same cycle as a read uses the old page
      cyc(1, 2'b01, 0, 16'd4, 0, 1, 8'h80, "R11 old page used");
      // R10 configuration contents, with aliasing
      for (int i = 0; i < CDEP + 2; i++) begin
         cyc(1, 2'b00, 0, 16'(2*i), 0, 0, 0, "R10 cfg read-low");
         cyc(1, 2'b01, 0, 16'(2*i), 0, 0, 0, "R10 cfg read-high");
      end
      cyc(1, 2'b01, 1, 16'd3, 0, 0, 0, "R6 cfg phantom byte");
      // R9 configuration writes ignored and flagged
      cyc(1, 2'b10, 0, 16'd2, 16'h1234, 0, 0, "R9 cfg write-low");
      cyc(1, 2'b11, 0, 16'd2, 16'h1234, 0, 0, "R9 cfg write-high");
      cyc(0, 0, 0, 0, 0, 0, 0, "R9 pulse ends");
      cyc(1, 2'b00, 0, 16'd2, 0, 0, 0, "R9 cfg unchanged lo");
      cyc(1, 2'b01, 0, 16'd2, 0, 0, 0, "R9 cfg unchanged hi");
      cyc(1, 2'b00, 0, 16'd2, 0, 1, 8'h00, "R9 switch back");
      cyc(1, 2'b00, 0, 16'd2, 0, 0, 0, "R9 user word intact");
      // R1: reset clears page, keeps memory
      cyc(0, 0, 0, 0, 0, 1, 8'h80, "R1 page to cfg");
      do_reset();
      for (int i = 0; i < 4; i++) cyc(1, 2'b00, 0, 16'(2*i), 0, 0, 0, "R1 memory kept");
      cyc(1, 2'b01, 0, 16'd2, 0, 0, 0, "R1 page cleared");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule